// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This unit gathers the event flags raised by a serial bus master engine and presents them to software through three 16-bit registers: a status register whose flags are cleared by writing ones, an enable register that selects which flags drive the interrupt line, and a legacy vector register that returns a small code for the most urgent pending transfer event and clears that event when read. The bus engine drives one-cycle pulses for arbitration loss, missing acknowledge, access completion, receive and transmit readiness, receive and transmit drain, receive overrun and transmit underflow. It also drives a level that shows whether the bus is busy.

Software reads and writes the registers over a simple synchronous port. The port uses a write strobe, a read strobe, a word address and a 16-bit data word, and read data is registered. The single interrupt output is also registered. It tracks the masked status exactly, with no extra cycle of lag.

Top module: `irq_status_unit`

## Requirements
- R1: A one-cycle event pulse sets its status flag on the next clock edge. The flag positions are: arbitration lost at bit 0, no-acknowledge at bit 1, access ready at bit 2, receive ready at bit 3, transmit ready at bit 4, transmit underflow at bit 10, receive overrun at bit 11, receive drain at bit 13 and transmit drain at bit 14. Bits 5-7, 8, 9 and 15 always read 0.
- R2: Writing the status register (address 0) with a 1 in a flag position clears that flag.
- R3: A 0 written to a status bit leaves that flag unchanged.
- R4: When an event pulse and a clearing write (or a vector-read clear) hit the same flag in the same cycle, the flag remains set.
- R5: Only bits 0-4, 13 and 14 of the enable register (address 1) can be written. Its other bits read as 0.
- R6: `irq` is high in exactly those cycles in which the bitwise AND of the status flags and the enable register is nonzero.
- R7: A read of the vector register (address 2) returns, in bits 2:0, code 0 when none of status bits 0-4 is set. Otherwise it returns the lowest code among those pending: 1 arbitration lost, 2 no-acknowledge, 3 access ready, 4 receive ready, 5 transmit ready. The enable register has no effect on this code.
- R8: A vector read clears only the flag whose code it returned, so successive reads walk through the pending events in code order.
- R9: Status bit 12 reads the live bus-busy level. Writes to bit 12 have no effect, and bus busy never raises `irq`.
- R10: A synchronous reset clears every status flag, every enable bit, `rdata` and `irq`.
- R11: Read data appears on `rdata` in the cycle after `rd_en`, and is 0 in any cycle that follows no read. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| evt_arb_lost | input | 1 | Arbitration lost pulse |
| evt_nack | input | 1 | No-acknowledge pulse |
| evt_acc_rdy | input | 1 | Access ready pulse |
| evt_rx_rdy | input | 1 | Receive data ready pulse |
| evt_tx_rdy | input | 1 | Transmit data ready pulse |
| evt_rx_drain | input | 1 | Receive drain pulse |
| evt_tx_drain | input | 1 | Transmit drain pulse |
| evt_rx_ovr | input | 1 | Receive overrun pulse |
| evt_tx_udf | input | 1 | Transmit underflow pulse |
| bus_busy | input | 1 | Live bus-busy level |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with the default two-bit address. This makes all four address values reachable, including the unused one that must read as zero. A behavioural model compares read data and the interrupt line on every clock. Directed phases cover each event position, clear-versus-set collisions and vector walks through stacked events. A long random phase then mixes pulses, writes, vector reads and bus-busy changes, so that same-cycle collisions between all three update sources occur many times.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int REG_W   = 16;
  localparam int VEC_N   = 5;
  localparam int VEC_W   = $clog2(VEC_N + 1);
  localparam int BUSY_B  = 12;
  // flag positions that hold sticky event state
  localparam logic [REG_W-1:0] EVT_MASK = 16'h6C1F;
  // writable enable positions
  localparam logic [REG_W-1:0] EN_MASK  = 16'h601F;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_VECTOR = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int W = 16,
  parameter logic [W-1:0] FLAG_MASK = '1,
  parameter logic [W-1:0] ENA_MASK  = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr,
  input  logic         en_we,
  input  logic [W-1:0] en_wdata,
  output logic [W-1:0] flags_q,
  output logic [W-1:0] en_q,
  output logic         irq_q
);
  logic [W-1:0] flags_d, en_d;

  always_comb begin
    flags_d = ((flags_q & ~clr) | evt) & FLAG_MASK;
    en_d    = en_we ? (en_wdata & ENA_MASK) : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      en_q    <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      en_q    <= en_d;
      irq_q   <= |(flags_d & en_d);
    end
  end

  assert_irq_R6: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(flags_q & en_q));

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (flags_q == '0 && en_q == '0 && !irq_q));

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (FLAG_MASK[i]) begin : g_live
      assert_set_R1: assert property (@(posedge clk) disable iff (rst)
        evt[i] |=> flags_q[i]);
      assert_w1c_R2: assert property (@(posedge clk) disable iff (rst)
        (clr[i] && !evt[i]) |=> !flags_q[i]);
      assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!clr[i] && !evt[i]) |=> (flags_q[i] == $past(flags_q[i])));
      assert_collide_R4: assert property (@(posedge clk) disable iff (rst)
        (clr[i] && evt[i]) |=> flags_q[i]);
    end else begin : g_dead
      assert_zero_R1: assert property (@(posedge clk) disable iff (rst)
        !flags_q[i]);
    end
  end
endmodule

// File: rtl/irq_vec_encoder.sv
module irq_vec_encoder #(
  parameter int N  = 5,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  pend,
  output logic [CW-1:0] code,
  output logic [N-1:0]  sel
);
  always_comb begin
    code = '0;
    sel  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        code   = CW'(i + 1);
        sel    = '0;
        sel[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_stat_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  input  logic              evt_arb_lost,
  input  logic              evt_nack,
  input  logic              evt_acc_rdy,
  input  logic              evt_rx_rdy,
  input  logic              evt_tx_rdy,
  input  logic              evt_rx_drain,
  input  logic              evt_tx_drain,
  input  logic              evt_rx_ovr,
  input  logic              evt_tx_udf,
  input  logic              bus_busy,
  output logic              irq
);
  logic [REG_W-1:0] evt_vec, clr_vec, flags_q, en_q, status_view;
  logic [VEC_W-1:0] vec_code;
  logic [VEC_N-1:0] vec_sel;
  logic             sel_st, sel_en, sel_vec;

  always_comb begin
    evt_vec     = '0;
    evt_vec[0]  = evt_arb_lost;
    evt_vec[1]  = evt_nack;
    evt_vec[2]  = evt_acc_rdy;
    evt_vec[3]  = evt_rx_rdy;
    evt_vec[4]  = evt_tx_rdy;
    evt_vec[10] = evt_tx_udf;
    evt_vec[11] = evt_rx_ovr;
    evt_vec[13] = evt_rx_drain;
    evt_vec[14] = evt_tx_drain;
  end

  assign sel_st  = (addr == ADDR_W'(SEL_STATUS));
  assign sel_en  = (addr == ADDR_W'(SEL_ENABLE));
  assign sel_vec = (addr == ADDR_W'(SEL_VECTOR));

  always_comb begin
    clr_vec = (wr_en && sel_st) ? wdata : '0;
    if (rd_en && sel_vec)
      clr_vec[VEC_N-1:0] = clr_vec[VEC_N-1:0] | vec_sel;
  end

  irq_flag_bank #(
    .W(REG_W), .FLAG_MASK(EVT_MASK), .ENA_MASK(EN_MASK)
  ) u_bank (
    .clk(clk), .rst(rst), .evt(evt_vec), .clr(clr_vec),
    .en_we(wr_en && sel_en), .en_wdata(wdata),
    .flags_q(flags_q), .en_q(en_q), .irq_q(irq)
  );

  irq_vec_encoder #(.N(VEC_N), .CW(VEC_W)) u_enc (
    .pend(flags_q[VEC_N-1:0]), .code(vec_code), .sel(vec_sel)
  );

  always_comb begin
    status_view         = flags_q;
    status_view[BUSY_B] = bus_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (sel_st)       rdata <= status_view;
      else if (sel_en)  rdata <= en_q;
      else if (sel_vec) rdata <= REG_W'(vec_code);
      else              rdata <= '0;
    end else begin
      rdata <= '0;
    end
  end

  assert_vec_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel_vec) |=>
      ((flags_q[VEC_N-1:0] & $past(vec_sel & ~evt_vec[VEC_N-1:0])) == '0));

  assert_vec_code_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel_vec && flags_q[0]) |=> (rdata == 16'd1));

  assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));

  assert_busy_noirq_R9: assert property (@(posedge clk) disable iff (rst)
    (flags_q & en_q) == '0 |-> !irq);
endmodule

// File: tb/irq_status_unit_tb_top.sv
module irq_status_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] evt = 16'd0;
  logic        bus_busy = 1'b0;
  logic [15:0] rdata;
  logic        irq;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R10";

  // behavioural reference state
  logic [15:0] m_st = 16'd0, m_en = 16'd0, m_rd = 16'd0;
  logic        m_irq = 1'b0;

  always #4 clk = ~clk;

  irq_status_unit #(.ADDR_W(2)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata),
    .evt_arb_lost(evt[0]), .evt_nack(evt[1]), .evt_acc_rdy(evt[2]),
    .evt_rx_rdy(evt[3]), .evt_tx_rdy(evt[4]), .evt_rx_drain(evt[13]),
    .evt_tx_drain(evt[14]), .evt_rx_ovr(evt[11]), .evt_tx_udf(evt[10]),
    .bus_busy(bus_busy), .irq(irq)
  );

  function automatic int lowest_code(input logic [15:0] s);
    for (int k = 0; k < 5; k++) if (s[k]) return k + 1;
    return 0;
  endfunction

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic step();
    logic [15:0] clr, nxt;
    int          c;
    @(posedge clk);
    if (rst) begin
      m_st = 0; m_en = 0; m_rd = 0; m_irq = 0;
    end else begin
      clr = 0;
      m_rd = 0;
      c = lowest_code(m_st);
      if (rd_en) begin
        case (addr)
          2'd0: m_rd = (m_st & 16'hEFFF) | (bus_busy ? 16'h1000 : 16'h0);
          2'd1: m_rd = m_en;
          2'd2: m_rd = 16'(c);
          default: m_rd = 0;
        endcase
        if (addr == 2'd2 && c != 0) clr[c-1] = 1'b1;
      end
      if (wr_en && addr == 2'd0) clr = clr | wdata;
      nxt = ((m_st & ~clr) | evt) & 16'h6C1F;
      m_st = nxt;
      if (wr_en && addr == 2'd1) m_en = wdata & 16'h601F;
      m_irq = |(m_st & m_en);
    end
    @(negedge clk);
    check("rdata", rdata, m_rd);
    check("irq", {15'd0, irq}, {15'd0, m_irq});
    wr_en = 0; rd_en = 0; evt = 0; wdata = 0; addr = 0;
  endtask

  task automatic do_write(input logic [1:0] a, input logic [15:0] d, input logic [15:0] e);
    wr_en = 1; addr = a; wdata = d; evt = e; step();
  endtask

  task automatic do_read(input logic [1:0] a);
    rd_en = 1; addr = a; step();
  endtask

  task automatic pulse(input logic [15:0] e);
    evt = e; step();
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10: reset state
    cur_req = "R10";
    repeat (3) step();
    @(negedge clk); rst = 0;
    do_read(0); do_read(1); do_read(2);
    check("status after reset", rdata, 16'h0000);

    // R1: each event sets its own flag
    cur_req = "R1";
    for (int b = 0; b < 16; b++) begin
      pulse(16'(1) << b);
      do_read(0);
      do_write(0, 16'hFFFF, 0);
    end

    // R2 / R3: write one clears, write zero holds
    cur_req = "R2";
    pulse(16'h6C1F); do_write(0, 16'h0005, 0); do_read(0);
    check("after w1c", rdata, 16'h6C1A);
    cur_req = "R3";
    do_write(0, 16'h0000, 0); do_read(0);
    check("after zero write", rdata, 16'h6C1A);

    // R4: set wins over clear
    cur_req = "R4";
    do_write(0, 16'hFFFF, 16'h2002); do_read(0);
    check("collision", rdata, 16'h2002);
    do_write(0, 16'hFFFF, 0);

    // R5: enable register mask
    cur_req = "R5";
    do_write(1, 16'hFFFF, 0); do_read(1);
    check("enable mask", rdata, 16'h601F);

    // R6: interrupt follows masked status
    cur_req = "R6";
    do_write(1, 16'h0004, 0);
    pulse(16'h0008); pulse(16'h0004);
    do_write(0, 16'h0004, 0);
    pulse(16'h0400);
    do_write(1, 16'h0000, 0);
    do_write(0, 16'hFFFF, 0);

    // R7 / R8: vector walk over stacked events
    cur_req = "R7";
    pulse(16'h001F);
    cur_req = "R8";
    for (int k = 0; k < 6; k++) do_read(2);
    pulse(16'h0012); do_read(2);
    check("vector nack", rdata, 16'd2);
    rd_en = 1; addr = 2; evt = 16'h0001; step();
    do_read(2); do_read(2); do_read(2);

    // R9: bus busy is live and write-immune
    cur_req = "R9";
    do_write(1, 16'hFFFF, 0);
    bus_busy = 1; do_read(0);
    check("busy live", rdata, 16'h1000);
    do_write(0, 16'h1000, 0); do_read(0);
    bus_busy = 0; do_read(0);
    do_write(1, 16'h0000, 0);

    // R11: unused address and idle read data
    cur_req = "R11";
    pulse(16'h6C1F);
    do_read(3); step();
    do_write(0, 16'hFFFF, 0);

    // random mix of all update sources
    cur_req = "R4";
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      evt      = 16'($urandom) & 16'h7F1F;
      bus_busy = r[0];
      wr_en    = r[1] & r[2];
      rd_en    = r[3];
      addr     = r[5:4];
      wdata    = 16'($urandom);
      step();
    end

    // R10: reset mid-run clears everything
    cur_req = "R10";
    pulse(16'h6C1F); do_write(1, 16'hFFFF, 0);
    @(negedge clk); rst = 1; step(); rst = 0;
    do_read(0); do_read(1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule